// File: doc/BRIEF.md
# Cascadable Serial Configuration Register

This block is the configuration front end of a programmable pulse generator. A controller writes a 22-bit width code over three wires: a serial clock, a serial data line and an enable. While the enable is high, each rising edge of the serial clock shifts one bit into an internal shift register. The most significant bit comes first. The bit that leaves the top of the register appears on a serial output, so several units can be chained output-to-input and loaded in one burst.

The value in the shift register does not reach the generator straight away. A holding latch drives the generator's address input, and it takes a new value only when the enable falls. Because of this, a new code can be shifted in while a pulse is still running, and that pulse keeps its old width. All three pins are synchronised into the system clock domain and edge-detected there. The serial output carries an enable flag that stands in for a high-impedance driver. A one-cycle strobe marks each latch update.

Top module: `cfg_shift_latch`

## Requirements
- R1: While reset is held and in the first cycle after it, `word_out` is 0, `load_stb` is 0, `sdo_oe` is 0 and `sdo` is 0.
- R2: On each serial clock rising edge seen while enable is high, the shift register moves one place toward bit 21 and takes `sdi_in` into bit 0. Bits therefore enter in the order bit 21 first, bit 0 last.
- R3: Serial clock rising edges seen while enable is low leave the shift register unchanged.
- R4: While enable is high, `sdo` shows the shift register's bit 21. This is valid before the first clock edge, so the earlier contents leave in order from bit 21 down to bit 0.
- R5: `sdo_oe` is high exactly while the synchronised enable is high. While `sdo_oe` is low, `sdo` is 0.
- R6: A falling edge of enable copies the whole shift register into `word_out`. At no other time does `word_out` change, including while bits are being shifted.
- R7: `load_stb` is high for exactly one cycle per latch update. It is high in the first cycle in which `word_out` shows the new value.
- R8: When two units are chained, with the output of the first feeding the input of the second, 44 bits are shifted. After that, the second unit holds the first 22-bit group and the first unit holds the last group, each group having been sent bit 21 first.
- R9: A pin change takes effect on the third system clock edge after it. `sdo_oe` follows on the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock pin, asynchronous |
| en_in | input | 1 | Load enable pin, asynchronous |
| sdi_in | input | 1 | Serial data input pin |
| sdo | output | 1 | Serial data output (MSB of shift register) |
| sdo_oe | output | 1 | Drive enable for `sdo`; low means high impedance |
| word_out | output | 22 | Latched width code to the pulse generator |
| load_stb | output | 1 | One-cycle pulse on each latch update |

## Verification
Each pin passes through a two-flop synchroniser and an edge register. A change on a pin that is driven between clock edges therefore shows on `sdo_oe` after the second rising edge. A serial shift, and the `sdo` bit that follows from it, shows after the third edge, as do the latch copy and `load_stb`. The bench drives its pins on falling edges and holds each serial clock level for four cycles before sampling `sdo`. It checks the enable-fall sequence one falling edge at a time: `sdo_oe` is still high after the first edge, low after the second, and `load_stb` is high after the third. A monitor compares every strobe against a queue of expected words that the driver pushed when it dropped enable.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

    localparam int unsigned CFG_W_DEF  = 22;
    localparam int unsigned SYNC_DEF   = 2;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

    // The three serial pins travel together through the synchroniser so
    // that data stays aligned with its clock.
    typedef struct packed {
        logic sclk;
        logic en;
        logic sdi;
    } pins_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync
    import cfg_chain_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t din,
    output pins_t dout
);

    pins_t stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[i] <= '0;
            else     stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_edge_det.sv
module cfg_edge_det
    import cfg_chain_pkg::*;
#(
    parameter edge_sel_e SEL = EDGE_RISE
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    if (SEL == EDGE_RISE) begin : g_rise
        assign pulse = lvl & ~prev_q;
    end else begin : g_fall
        assign pulse = ~lvl & prev_q;
    end

endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
    parameter int unsigned W = 22
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         din,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (step) q <= {q[W-2:0], din};
    end

endmodule

// File: rtl/cfg_holding_latch.sv
module cfg_holding_latch #(
    parameter int unsigned W = 22
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         stb
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            stb <= 1'b0;
        end else begin
            stb <= capture;
            if (capture) q <= d;
        end
    end

endmodule

// File: rtl/cfg_shift_latch.sv
module cfg_shift_latch
    import cfg_chain_pkg::*;
#(
    parameter int unsigned CFG_W       = CFG_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_in,
    input  logic             en_in,
    input  logic             sdi_in,
    output logic             sdo,
    output logic             sdo_oe,
    output logic [CFG_W-1:0] word_out,
    output logic             load_stb
);

    localparam int unsigned MSB = CFG_W - 1;

    pins_t            pins_raw;
    pins_t            pins_s;
    logic             sclk_rise;
    logic             en_fall;
    logic             shift_step;
    logic [CFG_W-1:0] shift_q;

    assign pins_raw = '{sclk: sclk_in, en: en_in, sdi: sdi_in};

    cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pins_raw),
        .dout (pins_s)
    );

    cfg_edge_det #(.SEL(EDGE_RISE)) u_sclk_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl   (pins_s.sclk),
        .pulse (sclk_rise)
    );

    cfg_edge_det #(.SEL(EDGE_FALL)) u_en_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl   (pins_s.en),
        .pulse (en_fall)
    );

    assign shift_step = sclk_rise & pins_s.en;

    cfg_shifter #(.W(CFG_W)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .step (shift_step),
        .din  (pins_s.sdi),
        .q    (shift_q)
    );

    cfg_holding_latch #(.W(CFG_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .capture (en_fall),
        .d       (shift_q),
        .q       (word_out),
        .stb     (load_stb)
    );

    assign sdo_oe = pins_s.en;
    assign sdo    = pins_s.en ? shift_q[MSB] : 1'b0;

endmodule

// File: rtl/cfg_shift_latch_chk.sv
module cfg_shift_latch_chk #(
    parameter int unsigned W = 22
) (
    input logic         clk,
    input logic         rst,
    input logic         sdo,
    input logic         sdo_oe,
    input logic [W-1:0] word_out,
    input logic         load_stb,
    input logic [W-1:0] shift_q
);

    assert_oe_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> sdo == 1'b0);

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !load_stb |-> word_out == $past(word_out));

    assert_latch_copy_R6: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> word_out == $past(shift_q));

    assert_strobe_width_R7: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> !load_stb);

    assert_idle_shift_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(sdo_oe) |-> $stable(shift_q));

    assert_shift_dir_R2: assert property (@(posedge clk) disable iff (rst)
        (shift_q != $past(shift_q)) |-> shift_q[W-1:1] == $past(shift_q[W-2:0]));

endmodule

bind cfg_shift_latch cfg_shift_latch_chk #(.W(CFG_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .word_out (word_out),
    .load_stb (load_stb),
    .shift_q  (shift_q)
);

// File: tb/cfg_shift_latch_bench.sv
module cfg_shift_latch_bench;
    import cfg_chain_pkg::*;

    localparam int unsigned W      = CFG_W_DEF;
    localparam time         CLK_PD = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk_in = 1'b0;
    logic         en_in = 1'b0;
    logic         sdi_in = 1'b0;
    logic         sdo, sdo_oe, load_stb;
    logic [W-1:0] word_out;
    logic         sdo_b, sdo_oe_b, load_stb_b;
    logic [W-1:0] word_out_b;

    int vectors = 0;
    int miscmp  = 0;
    bit done    = 1'b0;

    logic [W-1:0] m0 = '0;
    logic [W-1:0] m1 = '0;
    logic [W-1:0] expq[$];
    bit           prev_stb = 1'b0;

    always #(CLK_PD/2) clk = ~clk;

    cfg_shift_latch u_cfg_shift_latch (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .en_in(en_in), .sdi_in(sdi_in),
        .sdo(sdo), .sdo_oe(sdo_oe), .word_out(word_out), .load_stb(load_stb)
    );

    cfg_shift_latch u_cfg_shift_latch_next (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .en_in(en_in), .sdi_in(sdo),
        .sdo(sdo_b), .sdo_oe(sdo_oe_b), .word_out(word_out_b), .load_stb(load_stb_b)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: each strobe pops the next expected word (R6, R7).
    always @(negedge clk) begin
        if (!rst) begin
            if (load_stb) begin
                if (expq.size() == 0) check("R7 unexpected strobe", 1, 0);
                else check("R6 latched word", word_out, expq.pop_front());
                if (prev_stb) check("R7 strobe width", 2, 1);
            end
            prev_stb = load_stb;
        end
    end

    task automatic clk_bit(input logic b, input bit chk);
        sdi_in = b;
        tick(2);
        sclk_in = 1'b1;
        if (en_in) begin
            m1 = {m1[W-2:0], m0[W-1]};
            m0 = {m0[W-2:0], b};
        end
        tick(4);
        if (chk) check("R4 sdo next old bit", W'(sdo), W'(m0[W-1] & en_in));
        sclk_in = 1'b0;
        tick(4);
    endtask

    task automatic drop_en();
        en_in = 1'b0;
        expq.push_back(m0);
        tick(1);
        check("R9 oe still high after one edge", W'(sdo_oe), 1);
        tick(1);
        check("R9 oe low after two edges", W'(sdo_oe), 0);
        check("R9 no strobe yet", W'(load_stb), 0);
        tick(1);
        check("R9 strobe after three edges", W'(load_stb), 1);
        tick(3);
    endtask

    task automatic load_word(input logic [W-1:0] v);
        logic [W-1:0] held;
        held = word_out;
        en_in = 1'b1;
        tick(4);
        check("R5 oe high", W'(sdo_oe), 1);
        check("R4 sdo msb before first edge", W'(sdo), W'(m0[W-1]));
        for (int i = W - 1; i >= 0; i--) begin
            clk_bit(v[i], 1'b1);
            if (i == W / 2) check("R6 latch held while shifting", word_out, held);
        end
        drop_en();
        check("R2 shifted word msb first", word_out, v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscmp++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    initial begin
        tick(3);
        check("R1 word in reset", word_out, '0);
        check("R1 oe in reset", W'(sdo_oe), 0);
        rst = 1'b0;
        tick(1);
        check("R1 word after reset", word_out, '0);
        check("R1 strobe after reset", W'(load_stb), 0);
        check("R1 sdo after reset", W'(sdo), 0);
        check("R5 oe low idle", W'(sdo_oe), 0);

        load_word(22'h35A5C3);
        load_word(22'h3FFFFF);
        load_word(22'h000001);

        // R3: clocks while enable low are ignored.
        for (int i = 0; i < 5; i++) clk_bit(1'b1, 1'b0);
        check("R5 sdo quiet while disabled", W'(sdo), 0);
        check("R6 word unchanged by idle clocks", word_out, 22'h000001);
        en_in = 1'b1;
        tick(4);
        check("R3 msb unchanged after idle clocks", W'(sdo), 0);
        for (int i = W - 1; i >= 0; i--) clk_bit(1'b0, 1'b1);
        drop_en();
        check("R3 old content still shifted out as zero", word_out, '0);

        // R8: two-unit chain, far unit group first.
        en_in = 1'b1;
        tick(4);
        for (int i = W - 1; i >= 0; i--) clk_bit(22'h2C3A1F >> i, 1'b1);
        for (int i = W - 1; i >= 0; i--) clk_bit(22'h15E0B6 >> i, 1'b1);
        drop_en();
        check("R8 near unit holds last group", word_out, 22'h15E0B6);
        check("R8 far unit holds first group", word_out_b, 22'h2C3A1F);
        check("R8 far unit model", word_out_b, m1);

        tick(5);
        check("R7 all strobes consumed", W'(expq.size()), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule